// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block is the feedback divider of a digitally modelled fractional-N frequency synthesizer. It counts cycles of a fast input clock, which stands in for the oscillator, and emits one single-cycle pulse at the end of every division period. On average it divides by `div_int + div_frac/div_mod`. Each period divides by either the integer setting N or by N+1. The choice comes from a first-order modular accumulator that adds the fractional numerator once per period and overflows at the modulus.

One period is built from a dual-modulus prescaler, a main counter and a swallow counter. The prescaler divides by P or by P+1, where P is 4 or 8. For a period of length N, the main count is B = N div P and the swallow count is A = N mod P. The prescaler runs at P+1 for the first A passes and at P for the remaining B-A passes, so the period lasts P*B + A = N cycles.

Settings are sampled only at period boundaries. A sampled set that breaks the legality rules raises an error flag, and the previous set stays in use. A hold input freezes the counters with the output quiet, and a synchronous reset also clears the accumulator and restores default settings.

Top module: `fracn_fbdiv`

## Requirements
- R1: Over any MOD consecutive periods taken with constant legal settings, the total number of input cycles equals INT*MOD + FRAC.
- R2: A sampled set with MOD below 2 or FRAC not below MOD is rejected: `cfg_err` is 1 from the boundary where the set was sampled, the previously accepted settings stay in use, and the next legal sample clears `cfg_err`.
- R3: `pre_sel` = 0 selects the 4/5 prescaler and `pre_sel` = 1 selects the 8/9 prescaler. INT is legal from 23 (4/5) or from 75 (8/9) up to 65535. A sample with INT below the limit for its mode is rejected as in R2.
- R4: The spacing between consecutive output pulses is exactly the effective N of that period, built as P*(N div P) + (N mod P), where the first N mod P prescaler passes last P+1 cycles.
- R5: Each period divides by INT+1 exactly when the accumulator value plus FRAC reaches MOD, and by INT otherwise. The accumulator then holds the sum reduced modulo MOD. The accumulator is cleared by reset and whenever a newly accepted set carries a different MOD.
- R6: While `hold` is 1, no output pulse occurs and the counters restart. The first pulse after `rst` and `hold` are both low is high N+1 cycles after the first cycle in which both are low. The accumulator and accepted settings are kept across hold.
- R7: `div_pulse` is high for exactly one input-clock cycle per period.
- R8: Inputs that change in the middle of a period do not affect that period. They are sampled at its closing edge and apply to the next period.
- R9: Reset drives `div_pulse` and `cfg_err` to 0 and restores the defaults INT=100, FRAC=0, MOD=2 and 4/5 mode. These defaults stay in use if the first sample after reset is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Holds all counters at rest and keeps the output quiet |
| div_int | input | 16 | Integer part of the division ratio |
| div_frac | input | 12 | Fractional numerator |
| div_mod | input | 12 | Fractional modulus |
| pre_sel | input | 1 | Prescaler select: 0 = 4/5, 1 = 8/9 |
| div_pulse | output | 1 | One-cycle pulse that closes each division period |
| cfg_err | output | 1 | Set when the last sampled settings were rejected |

## Verification
The hardest situations to reach are those that depend on timing relative to the period boundary. One is an input change that lands mid-period, which must leave that period untouched. Another is a rejected setting, which must keep the old ratio while flagging the error. A third is a hold that cuts a period short without disturbing the accumulator. The bench tracks every observed pulse and drives new settings either right after a pulse or a fixed number of cycles into the period. A bench model advances its own accumulator at each boundary, and constrained random ratios are then summed over full MOD-period windows.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    localparam int INT_W      = 16;
    localparam int MOD_W      = 12;
    localparam int PRE_LO     = 4;
    localparam int PRE_HI     = 8;
    localparam int INT_MIN_LO = 23;
    localparam int INT_MIN_HI = 75;
    localparam int MOD_MIN    = 2;
    localparam int DEF_MOD    = 2;

    localparam int N_W    = INT_W + 1;
    localparam int SH_LO  = $clog2(PRE_LO);
    localparam int SH_HI  = $clog2(PRE_HI);
    localparam int MAIN_W = N_W - SH_LO;
    localparam int SWL_W  = SH_HI;
    localparam int PCNT_W = $clog2(PRE_HI + 1);

    typedef enum logic {
        PRE_4_5 = 1'b0,
        PRE_8_9 = 1'b1
    } pre_mode_e;

    typedef struct packed {
        logic [INT_W-1:0] int_part;
        logic [MOD_W-1:0] frac;
        logic [MOD_W-1:0] modulus;
        pre_mode_e        mode;
    } div_cfg_t;

    function automatic logic cfg_legal(input div_cfg_t c);
        logic [INT_W-1:0] lo;
        lo = (c.mode == PRE_8_9) ? INT_W'(INT_MIN_HI) : INT_W'(INT_MIN_LO);
        return (c.modulus >= MOD_W'(MOD_MIN)) && (c.frac < c.modulus) &&
               (c.int_part >= lo);
    endfunction

    function automatic logic [PCNT_W-1:0] pre_len(input pre_mode_e m);
        return (m == PRE_8_9) ? PCNT_W'(PRE_HI) : PCNT_W'(PRE_LO);
    endfunction

endpackage

// File: rtl/fracn_cfg_gate.sv
module fracn_cfg_gate
    import fracn_pkg::*;
#(
    parameter int DEF_INT = 100
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  div_cfg_t req,
    output div_cfg_t eff,
    output div_cfg_t act,
    output logic     mod_new,
    output logic     cfg_err
);

    localparam div_cfg_t CFG_DEF = '{
        int_part: INT_W'(DEF_INT),
        frac:     '0,
        modulus:  MOD_W'(DEF_MOD),
        mode:     PRE_4_5
    };

    logic legal;

    always_comb begin
        legal   = cfg_legal(req);
        eff     = legal ? req : act;
        mod_new = legal && (req.modulus != act.modulus);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= CFG_DEF;
            cfg_err <= 1'b0;
        end else if (load) begin
            if (legal) begin
                act <= req;
            end
            cfg_err <= !legal;
        end
    end

endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             mod_new,
    input  logic [MOD_W-1:0] frac,
    input  logic [MOD_W-1:0] modulus,
    output logic             carry,
    output logic [MOD_W-1:0] acc_q
);

    logic [MOD_W-1:0] base;
    logic [MOD_W:0]   sum;
    logic [MOD_W:0]   nxt;

    always_comb begin
        base  = mod_new ? '0 : acc_q;
        sum   = {1'b0, base} + {1'b0, frac};
        carry = (sum >= {1'b0, modulus});
        nxt   = carry ? (sum - {1'b0, modulus}) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= nxt[MOD_W-1:0];
        end
    end

endmodule

// File: rtl/fracn_dm_counter.sv
module fracn_dm_counter
    import fracn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [N_W-1:0]    n_div,
    input  pre_mode_e         mode,
    output logic              load,
    output logic              div_pulse,
    output logic              run_q,
    output logic [MAIN_W-1:0] main_q,
    output logic [SWL_W-1:0]  swal_q
);

    pre_mode_e         mode_q;
    logic [PCNT_W-1:0] pre_q;
    logic [MAIN_W-1:0] main_ld;
    logic [SWL_W-1:0]  swal_ld;
    logic [PCNT_W-1:0] pre_ld;
    logic [SWL_W-1:0]  swal_dec;
    logic [PCNT_W-1:0] p_run;
    logic              period_end;

    always_comb begin
        if (mode == PRE_8_9) begin
            main_ld = MAIN_W'(n_div >> SH_HI);
            swal_ld = SWL_W'(n_div[SH_HI-1:0]);
        end else begin
            main_ld = MAIN_W'(n_div >> SH_LO);
            swal_ld = SWL_W'(n_div[SH_LO-1:0]);
        end
        pre_ld     = (swal_ld != '0) ? pre_len(mode) : pre_len(mode) - PCNT_W'(1);
        swal_dec   = (swal_q != '0) ? swal_q - SWL_W'(1) : '0;
        p_run      = pre_len(mode_q);
        period_end = run_q && (pre_q == '0) && (main_q == MAIN_W'(1));
        load       = !rst && !hold && (!run_q || period_end);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            run_q     <= 1'b0;
            pre_q     <= '0;
            main_q    <= '0;
            swal_q    <= '0;
            mode_q    <= PRE_4_5;
            div_pulse <= 1'b0;
        end else if (load) begin
            run_q     <= 1'b1;
            main_q    <= main_ld;
            swal_q    <= swal_ld;
            pre_q     <= pre_ld;
            mode_q    <= mode;
            div_pulse <= period_end;
        end else begin
            div_pulse <= 1'b0;
            if (pre_q == '0) begin
                main_q <= main_q - MAIN_W'(1);
                swal_q <= swal_dec;
                pre_q  <= (swal_dec != '0) ? p_run : p_run - PCNT_W'(1);
            end else begin
                pre_q <= pre_q - PCNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/fracn_fbdiv.sv
module fracn_fbdiv
    import fracn_pkg::*;
#(
    parameter int DEF_INT = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [INT_W-1:0] div_int,
    input  logic [MOD_W-1:0] div_frac,
    input  logic [MOD_W-1:0] div_mod,
    input  logic             pre_sel,
    output logic             div_pulse,
    output logic             cfg_err
);

    div_cfg_t          req_cfg;
    div_cfg_t          eff_cfg;
    div_cfg_t          act_cfg;
    logic              mod_new;
    logic              carry;
    logic              load;
    logic              run_q;
    logic [MOD_W-1:0]  acc_q;
    logic [MAIN_W-1:0] main_q;
    logic [SWL_W-1:0]  swal_q;
    logic [N_W-1:0]    n_div;

    always_comb begin
        req_cfg.int_part = div_int;
        req_cfg.frac     = div_frac;
        req_cfg.modulus  = div_mod;
        req_cfg.mode     = pre_sel ? PRE_8_9 : PRE_4_5;
        n_div            = {1'b0, eff_cfg.int_part} + N_W'(carry);
    end

    fracn_cfg_gate #(.DEF_INT(DEF_INT)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .req     (req_cfg),
        .eff     (eff_cfg),
        .act     (act_cfg),
        .mod_new (mod_new),
        .cfg_err (cfg_err)
    );

    fracn_accum u_acc (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .mod_new (mod_new),
        .frac    (eff_cfg.frac),
        .modulus (eff_cfg.modulus),
        .carry   (carry),
        .acc_q   (acc_q)
    );

    fracn_dm_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .n_div     (n_div),
        .mode      (eff_cfg.mode),
        .load      (load),
        .div_pulse (div_pulse),
        .run_q     (run_q),
        .main_q    (main_q),
        .swal_q    (swal_q)
    );

endmodule

// File: rtl/fracn_fbdiv_chk.sv
module fracn_fbdiv_chk
    import fracn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic              div_pulse,
    input logic              cfg_err,
    input logic              load,
    input logic              run_q,
    input logic [MAIN_W-1:0] main_q,
    input logic [SWL_W-1:0]  swal_q,
    input logic [MOD_W-1:0]  acc_q,
    input div_cfg_t          act
);

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!div_pulse && !cfg_err)); // R9

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        hold |=> !div_pulse); // R6

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse); // R7

    AST_CFG_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(act)); // R8

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $stable(act)); // R2

    AST_SWALLOW_FITS: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (MAIN_W'(swal_q) <= main_q)); // R4

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        acc_q < act.modulus); // R5

    AST_INT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        act.int_part >= ((act.mode == PRE_8_9) ? INT_W'(INT_MIN_HI)
                                               : INT_W'(INT_MIN_LO))); // R3

endmodule

bind fracn_fbdiv fracn_fbdiv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err),
    .load      (load),
    .run_q     (run_q),
    .main_q    (main_q),
    .swal_q    (swal_q),
    .acc_q     (acc_q),
    .act       (act_cfg)
);

// File: tb/fracn_fbdiv_test.sv
`timescale 1ns/1ps
module fracn_fbdiv_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold = 1'b0;
    logic [15:0] i_int = 16'd100;
    logic [11:0] i_frac = 12'd0;
    logic [11:0] i_mod = 12'd2;
    logic        i_ps = 1'b0;
    logic        div_pulse;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;

    int m_int = 100, m_frac = 0, m_mod = 2, m_ps = 0, m_acc = 0;
    int exp_len = 0;
    bit exp_err = 1'b0;

    always #10 clk = ~clk;

    fracn_fbdiv uut (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .div_int   (i_int),
        .div_frac  (i_frac),
        .div_mod   (i_mod),
        .pre_sel   (i_ps),
        .div_pulse (div_pulse),
        .cfg_err   (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_int = 100; m_frac = 0; m_mod = 2; m_ps = 0; m_acc = 0;
    endtask

    // Bench model of one boundary: sample inputs, apply legality rules, step accumulator
    task automatic model_load();
        int lo;
        int sum;
        bit ok;
        lo  = i_ps ? 75 : 23;
        ok  = (int'(i_mod) >= 2) && (int'(i_frac) < int'(i_mod)) && (int'(i_int) >= lo);
        if (ok) begin
            if (int'(i_mod) != m_mod) m_acc = 0;
            m_int = int'(i_int); m_frac = int'(i_frac); m_mod = int'(i_mod); m_ps = int'(i_ps);
        end
        exp_err = !ok;
        sum = m_acc + m_frac;
        if (sum >= m_mod) begin
            m_acc = sum - m_mod;
            exp_len = m_int + 1;
        end else begin
            m_acc = sum;
            exp_len = m_int;
        end
    endtask

    task automatic set_in(input int a, input int f, input int m, input int p);
        i_int  = 16'(a);
        i_frac = 12'(f);
        i_mod  = 12'(m);
        i_ps   = p[0];
    endtask

    task automatic next_period(input string req, input int pre_len, input bit first, output int len);
        int want;
        want = first ? exp_len + 1 : exp_len;
        len = pre_len;
        do begin
            @(negedge clk);
            len++;
            if (len == 1 && !first) chk(div_pulse == 1'b0, "R7", int'(div_pulse), 0);
        end while (!div_pulse);
        chk(len == want, req, len, want);
        model_load();
        chk(cfg_err == exp_err, "R2", int'(cfg_err), int'(exp_err));
    endtask

    task automatic run_n(input string req, input int n);
        int len;
        repeat (n) next_period(req, 0, 1'b0, len);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(div_pulse == 1'b0, "R9", int'(div_pulse), 0);
        chk(cfg_err == 1'b0, "R9", int'(cfg_err), 0);
        model_reset();
    endtask

    // Called at a negedge; releases rst and hold and measures the first period
    task automatic start_run(input string req);
        int len;
        rst  = 1'b0;
        hold = 1'b0;
        model_load();
        @(negedge clk);
        chk(cfg_err == exp_err, req, int'(cfg_err), int'(exp_err));
        next_period(req, 1, 1'b1, len);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", n_chk, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int len;
        int total;
        int lo, ri, rm, rf, rp;
        void'($urandom(32'd7321));

        // R9: illegal first sample after reset falls back to defaults
        set_in(40, 5, 3, 0);
        do_reset();
        start_run("R9");
        run_n("R9", 2);
        do_reset();

        // R4 / R3: legal boundaries and rejected INT per prescaler mode
        set_in(23, 0, 2, 0);
        start_run("R4");
        run_n("R4", 2);
        set_in(22, 0, 2, 0);
        run_n("R3", 2);
        set_in(75, 0, 2, 1);
        run_n("R3", 2);
        set_in(74, 0, 2, 1);
        run_n("R3", 2);
        set_in(40, 0, 2, 1);
        run_n("R3", 2);
        set_in(23, 3, 4, 0);
        run_n("R4", 4);

        // R2: FRAC equal to MOD, MOD below 2, then recovery
        set_in(60, 7, 7, 0);
        run_n("R2", 2);
        set_in(60, 0, 1, 0);
        run_n("R2", 2);
        set_in(60, 3, 7, 0);
        run_n("R2", 8);

        // R8: change in the middle of a period
        set_in(50, 0, 2, 0);
        run_n("R8", 2);
        len = 0;
        repeat (9) begin
            @(negedge clk);
            len++;
        end
        set_in(90, 0, 2, 0);
        next_period("R8", len, 1'b0, len);
        run_n("R8", 2);

        // R5: accumulator restart on modulus change
        set_in(30, 1, 3, 0);
        run_n("R5", 6);
        set_in(30, 2, 5, 0);
        run_n("R5", 7);

        // R6: hold mid-period
        repeat (6) @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        repeat (40) begin
            @(negedge clk);
            chk(div_pulse == 1'b0, "R6", int'(div_pulse), 0);
        end
        start_run("R6");
        run_n("R6", 3);

        // R1: directed window with FRAC = MOD-1, then constrained random windows
        for (int t = 0; t < 8; t++) begin
            if (t == 0) begin
                rp = 0; ri = 23; rm = 12; rf = 11;
            end else if (t == 1) begin
                rp = 1; ri = 75; rm = 9; rf = 0;
            end else begin
                rp = int'($urandom_range(0, 1));
                lo = (rp == 1) ? 75 : 23;
                ri = lo + int'($urandom_range(0, 80));
                rm = int'($urandom_range(2, 24));
                rf = int'($urandom_range(0, rm - 1));
            end
            set_in(ri, rf, rm, rp);
            do_reset();
            start_run("R5");
            total = 0;
            for (int k = 0; k < rm; k++) begin
                next_period("R5", 0, 1'b0, len);
                total += len;
            end
            chk(total == ri * rm + rf, "R1", total, ri * rm + rf);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule